// File: doc/BRIEF.md
# Message Schedule Expander for a 224-bit SHA-2 Hash Core

This block turns one 512-bit message block into the 64-word message schedule of the 224-bit SHA-2 hash. It hands out one 32-bit word per accepted transfer on a valid/ready output port. A compression datapath next to it consumes the words, one per round.

A one-cycle load strobe captures the block. The first sixteen words produced are the block's own words, most significant word first. Every later word is computed on the fly from earlier words. The recurrence uses two small sigma functions and modular addition, all taken from a sixteen-entry shift window. Because of this, the block never stores a 64-entry schedule.

After the sixty-fourth word is accepted, the block pulses a done flag and waits idle for the next load. Round constants and the compression rounds are not part of this block.

Top module: `msg_sched_expander`

## Requirements
- R1: While reset is low, and on the first cycle after it, `wout_valid_o` and `block_done_o` are 0.
- R2: On the cycle after `load_i` is high, `wout_valid_o` is 1. On that same cycle `wout_idx_o` is 0 and `wout_data_o` equals `block_i[511:480]`.
- R3: Word k, for k from 0 to 15, equals `block_i[511-32k -: 32]`, so words are taken in big-endian order.
- R4: The lower sigma of x is ror(x,7) xor ror(x,18) xor (x >> 3), where the shift is logical. For example, a block whose only nonzero word is word 1 = 0x00000001 yields word 16 = 0x02004000.
- R5: The upper sigma of x is ror(x,17) xor ror(x,19) xor (x >> 10), where the shift is logical. For example, a block whose only nonzero word is word 14 = 0x00000001 yields word 16 = 0x0000A000.
- R6: For i from 16 to 63, word i = word(i-16) + lower sigma(word(i-15)) + word(i-7) + upper sigma(word(i-2)), taken modulo 2^32.
- R7: Each accepted transfer (valid and ready high at a clock edge) advances `wout_idx_o` by one. Exactly 64 words, with indices 0 to 63, are offered per block.
- R8: While `wout_valid_o` is 1 and `wout_ready_i` is 0, `wout_data_o` and `wout_idx_o` hold their values into the next cycle.
- R9: On the cycle after word 63 is accepted, `block_done_o` is 1 for exactly one cycle and `wout_valid_o` is 0.
- R10: A load during an unfinished schedule abandons it. The next cycle restarts at index 0 with the new block's word 0.
- R11: While idle, `wout_ready_i` has no effect: `wout_valid_o` stays 0 until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Strobe that captures `block_i` and starts a schedule |
| block_i | input | 512 | Message block, word 0 in the top 32 bits |
| wout_ready_i | input | 1 | Consumer accepts the offered word |
| wout_valid_o | output | 1 | A schedule word is offered |
| wout_data_o | output | 32 | Offered schedule word |
| wout_idx_o | output | 6 | Index of the offered word, 0 to 63 |
| block_done_o | output | 1 | One-cycle pulse after word 63 is accepted |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 64-word schedule and a 16-entry window. At that size every one of the 64 indices of each block can be compared against a schedule that the bench computes arithmetically. Several block patterns are used: all zeros, all ones, single-bit words that isolate each sigma, a carry-overflow case, a padded short message and pseudo-random data. Four ready patterns are used: continuous, alternating, pseudo-random and sparse. Together they exercise window shifts under stalls, restarts mid-schedule and the idle state after done.

// File: rtl/sched_pkg.sv
// Package: shared constants and sigma functions for the schedule expander.
// Assumes a 32-bit word; the rotation amounts are fixed by the hash algorithm.
package sched_pkg;

    localparam int SCHED_WORD_W = 32;

    // Lags of the recurrence relative to the word being produced
    localparam int LAG_OLDEST = 16;
    localparam int LAG_LO_SIG = 15;
    localparam int LAG_MID    = 7;
    localparam int LAG_HI_SIG = 2;

    // Rotate right of a schedule word
    function automatic logic [SCHED_WORD_W-1:0] rot_r(
        input logic [SCHED_WORD_W-1:0] x,
        input int                      n
    );
        return (x >> n) | (x << (SCHED_WORD_W - n));
    endfunction

    // Lower sigma: applied to the word fifteen places back
    function automatic logic [SCHED_WORD_W-1:0] sig_lo(
        input logic [SCHED_WORD_W-1:0] x
    );
        return rot_r(x, 7) ^ rot_r(x, 18) ^ (x >> 3);
    endfunction

    // Upper sigma: applied to the word two places back
    function automatic logic [SCHED_WORD_W-1:0] sig_hi(
        input logic [SCHED_WORD_W-1:0] x
    );
        return rot_r(x, 17) ^ rot_r(x, 19) ^ (x >> 10);
    endfunction

endpackage

// File: rtl/sched_ctrl.sv
// Module: sched_ctrl
// Tracks the index of the offered word, drives valid, and raises the
// done pulse after the last word. Assumes load takes priority over a
// transfer in the same cycle.
module sched_ctrl #(
    parameter int NUM_WORDS = 64,
    parameter int IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             shift_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    logic busy_q;

    // Sequence state: busy flag, word index and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (load_i) begin
                busy_q <= 1'b1;
                idx_o  <= '0;
            end else if (busy_q && ready_i) begin
                if (idx_o == LAST_IDX) begin
                    busy_q <= 1'b0;
                    idx_o  <= '0;
                    done_o <= 1'b1;
                end else begin
                    idx_o <= idx_o + IDX_W'(1);
                end
            end
        end
    end

    // Offer and window-advance strobes
    always_comb begin
        valid_o = busy_q;
        shift_o = busy_q & ready_i & ~load_i;
    end

endmodule

// File: rtl/sched_window.sv
// Module: sched_window
// Sixteen-entry shift register of schedule words. Slot 0 is the oldest
// word (the one on offer); a shift drops slot 0 and writes the new word
// into the top slot. A load fills all slots from the block, word 0 into
// slot 0. Assumes load and shift are never acted on together (load wins).
module sched_window #(
    parameter int WORD_W    = 32,
    parameter int WIN_DEPTH = 16,
    parameter int BLOCK_W   = WORD_W * WIN_DEPTH
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_i,
    input  logic                        shift_i,
    input  logic [BLOCK_W-1:0]          block_i,
    input  logic [WORD_W-1:0]           new_word_i,
    output logic [WIN_DEPTH*WORD_W-1:0] win_o
);

    for (genvar k = 0; k < WIN_DEPTH; k++) begin : g_slot
        logic [WORD_W-1:0] shift_src;

        // Source of this slot on a shift: next slot up, or the new word
        if (k == WIN_DEPTH - 1) begin : g_top
            always_comb shift_src = new_word_i;
        end else begin : g_mid
            always_comb shift_src = win_o[(k+1)*WORD_W +: WORD_W];
        end

        // Slot register: load from block, shift, or hold
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_o[k*WORD_W +: WORD_W] <= '0;
            end else if (load_i) begin
                win_o[k*WORD_W +: WORD_W] <= block_i[BLOCK_W-1-k*WORD_W -: WORD_W];
            end else if (shift_i) begin
                win_o[k*WORD_W +: WORD_W] <= shift_src;
            end
        end
    end

endmodule

// File: rtl/sched_next_word.sv
// Module: sched_next_word
// Combinational recurrence: computes the word sixteen places after the
// word in slot 0 from four window taps. Assumes slot 0 holds the oldest
// word of a sixteen-word run.
module sched_next_word
    import sched_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int WIN_DEPTH = 16
) (
    input  logic [WIN_DEPTH*WORD_W-1:0] win_i,
    output logic [WORD_W-1:0]           word_o
);

    localparam int TAP_OLD = WIN_DEPTH - LAG_OLDEST;
    localparam int TAP_LO  = WIN_DEPTH - LAG_LO_SIG;
    localparam int TAP_MID = WIN_DEPTH - LAG_MID;
    localparam int TAP_HI  = WIN_DEPTH - LAG_HI_SIG;

    logic [WORD_W-1:0] w_old, w_lo, w_mid, w_hi;
    logic [WORD_W-1:0] sum_a, sum_b;

    // Tap extraction from the flattened window
    always_comb begin
        w_old = win_i[TAP_OLD*WORD_W +: WORD_W];
        w_lo  = win_i[TAP_LO*WORD_W  +: WORD_W];
        w_mid = win_i[TAP_MID*WORD_W +: WORD_W];
        w_hi  = win_i[TAP_HI*WORD_W  +: WORD_W];
    end

    // Balanced adder tree, modulo the word width
    always_comb begin
        sum_a  = w_old + sig_lo(w_lo);
        sum_b  = w_mid + sig_hi(w_hi);
        word_o = sum_a + sum_b;
    end

endmodule

// File: rtl/msg_sched_expander.sv
// Module: msg_sched_expander
// Produces the 64-word message schedule of one 512-bit block, one word
// per accepted transfer. The offered word is always window slot 0, so
// the output has no combinational path from the inputs.
// Assumes WORD_W = 32 (the sigma rotations are defined for it).
module msg_sched_expander #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 64,
    parameter int WIN_DEPTH = 16,
    parameter int BLOCK_W   = WORD_W * WIN_DEPTH,
    parameter int IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [BLOCK_W-1:0] block_i,
    input  logic               wout_ready_i,
    output logic               wout_valid_o,
    output logic [WORD_W-1:0]  wout_data_o,
    output logic [IDX_W-1:0]   wout_idx_o,
    output logic               block_done_o
);

    logic                        shift;
    logic [WIN_DEPTH*WORD_W-1:0] win;
    logic [WORD_W-1:0]           next_word;

    sched_ctrl #(
        .NUM_WORDS (NUM_WORDS),
        .IDX_W     (IDX_W)
    ) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .ready_i (wout_ready_i),
        .valid_o (wout_valid_o),
        .idx_o   (wout_idx_o),
        .shift_o (shift),
        .done_o  (block_done_o)
    );

    sched_window #(
        .WORD_W    (WORD_W),
        .WIN_DEPTH (WIN_DEPTH),
        .BLOCK_W   (BLOCK_W)
    ) win_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .shift_i    (shift),
        .block_i    (block_i),
        .new_word_i (next_word),
        .win_o      (win)
    );

    sched_next_word #(
        .WORD_W    (WORD_W),
        .WIN_DEPTH (WIN_DEPTH)
    ) nxt_i (
        .win_i  (win),
        .word_o (next_word)
    );

    // Offered word is the oldest window slot
    always_comb wout_data_o = win[WORD_W-1:0];

endmodule

// File: rtl/sched_expander_chk.sv
// Module: sched_expander_chk
// Protocol checker for msg_sched_expander, attached by bind below.
// Assumes the checker sees the same clock and reset as the block.
module sched_expander_chk #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 64,
    parameter int BLOCK_W   = 512,
    parameter int IDX_W     = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load_i,
    input logic [BLOCK_W-1:0] block_i,
    input logic               wout_ready_i,
    input logic               wout_valid_o,
    input logic [WORD_W-1:0]  wout_data_o,
    input logic [IDX_W-1:0]   wout_idx_o,
    input logic               block_done_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WORDS - 1);

    logic xfer;
    always_comb xfer = wout_valid_o & wout_ready_i & ~load_i;

    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (wout_valid_o && wout_idx_o == '0)); // R2

    AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (wout_data_o == $past(block_i[BLOCK_W-1 -: WORD_W]))); // R10

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && wout_idx_o != LAST) |=>
            (wout_valid_o && wout_idx_o == ($past(wout_idx_o) + IDX_W'(1)))); // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wout_valid_o && !wout_ready_i && !load_i) |=>
            (wout_valid_o && $stable(wout_data_o) && $stable(wout_idx_o))); // R8

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && wout_idx_o == LAST) |=> (block_done_o && !wout_valid_o)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (block_done_o && !load_i) |=> !block_done_o); // R9

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wout_valid_o && !load_i) |=> !wout_valid_o); // R11

endmodule

bind msg_sched_expander sched_expander_chk #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS),
    .BLOCK_W   (BLOCK_W),
    .IDX_W     (IDX_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .block_i      (block_i),
    .wout_ready_i (wout_ready_i),
    .wout_valid_o (wout_valid_o),
    .wout_data_o  (wout_data_o),
    .wout_idx_o   (wout_idx_o),
    .block_done_o (block_done_o)
);

// File: tb/msg_sched_expander_tb_top.sv
// Bench for msg_sched_expander: reference schedule computed arithmetically,
// every index of every block compared under several ready patterns.
module msg_sched_expander_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [511:0] blk = '0;
    logic         ready = 1'b0;
    logic         valid;
    logic [31:0]  data;
    logic [5:0]   idx;
    logic         done;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] model [64];
    logic [31:0] lfsr = 32'h1D872B41;

    always #5 clk = ~clk;

    msg_sched_expander dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .block_i      (blk),
        .wout_ready_i (ready),
        .wout_valid_o (valid),
        .wout_data_o  (data),
        .wout_idx_o   (idx),
        .block_done_o (done)
    );

    function automatic logic [31:0] ref_s0(input logic [31:0] x);
        return {x[6:0], x[31:7]} ^ {x[17:0], x[31:18]} ^ {3'b000, x[31:3]};
    endfunction

    function automatic logic [31:0] ref_s1(input logic [31:0] x);
        return {x[16:0], x[31:17]} ^ {x[18:0], x[31:19]} ^ {10'd0, x[31:10]};
    endfunction

    task automatic build_model(input logic [511:0] b);
        for (int i = 0; i < 16; i++) model[i] = b[511 - 32*i -: 32];
        for (int i = 16; i < 64; i++)
            model[i] = 32'(64'(model[i-16]) + 64'(ref_s0(model[i-15]))
                         + 64'(model[i-7]) + 64'(ref_s1(model[i-2])));
    endtask

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic pick_ready(input int mode, input int cyc);
        case (mode)
            0: return 1'b1;
            1: return cyc[0];
            2: return lfsr[3] | lfsr[11];
            default: return (cyc % 4) == 3;
        endcase
    endfunction

    // Load a block and consume stop_after words under a ready pattern
    task automatic run_block(input logic [511:0] b, input int mode, input int stop_after);
        logic        held_v = 1'b0;
        logic [31:0] held_d = '0;
        logic [5:0]  held_i = '0;
        int          n = 0;
        int          cyc = 0;
        build_model(b);
        @(negedge clk);
        load = 1'b1; blk = b; ready = 1'b0;
        @(negedge clk);
        load = 1'b0;
        chk(valid == 1'b1 && idx == 6'd0, "R2 start", {26'd0, idx}, 32'd0);
        chk(data == b[511:480], "R2/R10 first word", data, b[511:480]);
        while (n < stop_after && cyc < 4000) begin
            if (held_v)
                chk(data == held_d && idx == held_i, "R8 stall hold", data, held_d);
            if (!valid) begin
                chk(1'b0, "R7 valid dropped early", {26'd0, idx}, n);
                break;
            end
            ready = pick_ready(mode, cyc);
            lfsr  = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (ready) begin
                chk(idx == 6'(n), "R7 index", {26'd0, idx}, n);
                if (n < 16) chk(data == model[n], "R3 block word", data, model[n]);
                else        chk(data == model[n], "R6 recurrence", data, model[n]);
                n++;
                held_v = 1'b0;
            end else begin
                held_v = 1'b1; held_d = data; held_i = idx;
            end
            @(negedge clk);
            cyc++;
        end
        if (stop_after == 64) begin
            chk(done == 1'b1 && valid == 1'b0, "R9 done pulse", {30'd0, done, valid}, 32'd2);
            ready = 1'b1;
            @(negedge clk);
            chk(done == 1'b0, "R9 single cycle", {31'd0, done}, 32'd0);
            chk(valid == 1'b0, "R11 idle ignores ready", {31'd0, valid}, 32'd0);
            @(negedge clk);
            chk(valid == 1'b0, "R11 still idle", {31'd0, valid}, 32'd0);
            ready = 1'b0;
        end
    endtask

    // Single-word block helper: word k set to v, all others zero
    function automatic logic [511:0] one_word(input int k, input logic [31:0] v);
        logic [511:0] b = '0;
        b[511 - 32*k -: 32] = v;
        return b;
    endfunction

    // Run word 16 only and compare with a hand value
    task automatic check_w16(input logic [511:0] b, input logic [31:0] exp, input string tag);
        @(negedge clk);
        load = 1'b1; blk = b; ready = 1'b0;
        @(negedge clk);
        load = 1'b0; ready = 1'b1;
        repeat (16) @(negedge clk);
        chk(idx == 6'd16 && data == exp, tag, data, exp);
        while (valid) @(negedge clk);
        ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [511:0] b;
        logic [511:0] pad_msg;
        repeat (3) @(negedge clk);
        chk(valid == 1'b0 && done == 1'b0, "R1 in reset", {30'd0, valid, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid == 1'b0 && done == 1'b0, "R1 after reset", {30'd0, valid, done}, 32'd0);

        // R4 / R5 / R6 hand-computed corner words
        check_w16(one_word(1, 32'h1), 32'h02004000, "R4 lower sigma");
        check_w16(one_word(14, 32'h1), 32'h0000A000, "R5 upper sigma");
        b = one_word(0, 32'hFFFFFFFF) | one_word(9, 32'hFFFFFFFF);
        check_w16(b, 32'hFFFFFFFE, "R6 wraparound");

        // Full schedules under every ready pattern
        run_block('0, 0, 64);
        run_block({512{1'b1}}, 1, 64);
        pad_msg = '0;
        pad_msg[511:480] = 32'h61626380;
        pad_msg[31:0]    = 32'h00000018;
        run_block(pad_msg, 2, 64);
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 16; k++) b[511 - 32*k -: 32] = $urandom();
            run_block(b, m, 64);
        end

        // R10 restart mid-schedule, then finish the new block
        for (int k = 0; k < 16; k++) b[511 - 32*k -: 32] = $urandom();
        run_block(b, 0, 21);
        for (int k = 0; k < 16; k++) b[511 - 32*k -: 32] = 32'h01010101 * (k + 1);
        run_block(b, 2, 64);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule